// File: doc/BRIEF.md
# Up/Down External Event Counter

This block counts transitions on an external event input. Both the event input and a second input that picks the count direction are taken into the system clock domain through synchroniser flops. Every rising and every falling edge of the synchronised event input becomes a one-cycle strobe. On each strobe the 16-bit counter moves one step. It counts up while the synchronised direction level is low and down while it is high. The direction input never acts as a count source.

Software uses a small write port to preload the counter and to set or clear the enable bit. A wrap past the top of the range (all ones to zero) or past the bottom (zero to all ones) produces a one-cycle interrupt pulse. The same wrap sets a sticky flag, which software clears by writing 1. While the block is disabled, edges are discarded and are not stored for later. A counter write in the same cycle as a strobe takes precedence over the strobe.

Top module: `updn_evt_cnt`

## Requirements
- R1: Each rising edge and each falling edge of evt_i moves the counter by exactly one step. count_o shows the new value on the third rising clock edge after the event edge is set up.
- R2: The step is +1 when dir_i, synchronised the same way as evt_i, is low at the strobe. The step is -1 when it is high. The direction may change between steps.
- R3: Counting up from 16'hFFFF gives 16'h0000, and irq_o is high for exactly one cycle, in the same cycle as the wrapped value.
- R4: Counting down from 16'h0000 gives 16'hFFFF, and irq_o is high for exactly one cycle, in the same cycle as the wrapped value.
- R5: A write with wr_addr_i = 0 loads wr_data_i into the counter on the next clock edge. This write wins over a strobe in the same cycle, and the strobe is then lost.
- R6: A write with wr_addr_i = 1 sets en_o to wr_data_i[0]. While en_o is 0, edges leave count_o unchanged and never pulse irq_o. Edges seen while disabled are not counted after enable.
- R7: While evt_i is held at a constant level, count_o does not change.
- R8: Every wrap sets flag_o. A write with wr_addr_i = 2 and wr_data_i[0] = 1 clears flag_o. Writing 0 there has no effect. A wrap in the same cycle as a clear leaves flag_o set.
- R9: After reset, count_o = 0, en_o = 0, flag_o = 0 and irq_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | External event input (count source) |
| dir_i | input | 1 | External direction input: 0 = up, 1 = down |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 counter, 1 control, 2 status |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Counter value |
| en_o | output | 1 | Enable bit |
| flag_o | output | 1 | Sticky wrap flag |
| irq_o | output | 1 | One-cycle wrap interrupt pulse |

## Verification
An event edge set up before clock edge 1 reaches the second synchroniser flop at edge 2. It then raises the strobe, so count_o and irq_o change at edge 3. The bench changes inputs on falling edges and samples on the third falling edge after an event toggle. It looks at irq_o there and again one cycle later to confirm a single-cycle pulse. Register writes take effect at the next rising edge and are sampled at the following falling edge. The priority cases (write against strobe, clear against wrap) present the write while the strobe is live, which is two falling edges after the toggle.

// File: rtl/updn_evt_pkg.sv
package updn_evt_pkg;
  typedef enum logic [1:0] {
    ADDR_CNT  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 1'b0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/updn_edge.sv
module updn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic stb_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= lvl_i;
  end

  // any level change, rising or falling
  assign stb_o = lvl_i ^ prev_q;
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_evt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             dir_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] cnt_q;
  logic en_q, flag_q, irq_q;
  logic wr_cnt, wr_ctl, wr_clr, step, wrap;

  assign wr_cnt = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_clr = wr_en_i && (wr_addr_i == ADDR_STAT) && wr_data_i[0];
  assign step   = stb_i && en_q && !wr_cnt;
  assign wrap   = step && (dir_i ? (cnt_q == CNT_MIN) : (cnt_q == CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_cnt)    cnt_q <= wr_data_i;
      else if (step) cnt_q <= dir_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
      if (wr_ctl) en_q <= wr_data_i[0];
      if (wrap)        flag_q <= 1'b1;
      else if (wr_clr) flag_q <= 1'b0;
      irq_q <= wrap;
    end
  end

  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/updn_evt_cnt.sv
module updn_evt_cnt #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             dir_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             en_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic evt_s, dir_s, evt_stb;

  updn_sync #(.STAGES(SYNC_STAGES)) u_sync_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(evt_s)
  );
  updn_sync #(.STAGES(SYNC_STAGES)) u_sync_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dir_i), .q_o(dir_s)
  );
  updn_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(evt_s), .stb_o(evt_stb)
  );
  updn_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (evt_stb),
    .dir_i    (dir_s),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_o    (count_o),
    .en_o     (en_o),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/updn_evt_cnt_chk.sv
module updn_evt_cnt_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stb,
  input logic             dir_s,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             en_o,
  input logic             flag_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  logic wr_cnt;
  assign wr_cnt = wr_en_i && (wr_addr_i == 2'd0);

  assert_step_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && en_o && !wr_cnt && !dir_s) |=> (count_o == $past(count_o) + 1'b1));

  assert_step_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && en_o && !wr_cnt && dir_s) |=> (count_o == $past(count_o) - 1'b1));

  assert_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_on_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((count_o == '0 && $past(count_o) == MAXV) ||
                      (count_o == MAXV && $past(count_o) == '0)));

  assert_preload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (count_o == $past(wr_data_i)));

  assert_hold_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !wr_cnt) |=> ($stable(count_o) && !irq_o));

  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

bind updn_evt_cnt updn_evt_cnt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stb      (evt_stb),
  .dir_s    (dir_s),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .count_o  (count_o),
  .en_o     (en_o),
  .flag_o   (flag_o),
  .irq_o    (irq_o)
);

// File: tb/updn_evt_cnt_tb_top.sv
`timescale 1ns/1ps
module updn_evt_cnt_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt = 1'b0, dir = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic en, flag, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  updn_evt_cnt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .dir_i(dir),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .en_o(en), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // flip evt, return at the negedge where the result is visible
  task automatic toggle();
    evt = ~evt;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_dir(logic v);
    dir = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 count", count, 0); chk("R9 en", en, 0);
    chk("R9 flag", flag, 0);   chk("R9 irq", irq, 0);
  endtask

  task automatic t_count_both_edges();
    wr(2'd0, 16'h8000); chk("R5 preload", count, 16'h8000);
    wr(2'd1, 16'h0001); chk("R6 enable", en, 1);
    toggle(); chk("R1 rising", count, 16'h8001);
    toggle(); chk("R1 falling", count, 16'h8002);
    set_dir(1'b1);
    toggle(); chk("R2 down", count, 16'h8001);
    toggle(); chk("R2 down2", count, 16'h8000);
    set_dir(1'b0);
    toggle(); chk("R2 up again", count, 16'h8001);
  endtask

  task automatic t_static();
    repeat (20) @(negedge clk);
    chk("R7 static evt", count, 16'h8001);
  endtask

  task automatic t_overflow();
    set_dir(1'b0);
    wr(2'd0, 16'hFFFE);
    toggle(); chk("R3 to FFFF", count, 16'hFFFF); chk("R3 no irq", irq, 0);
    toggle(); chk("R3 wrap", count, 16'h0000); chk("R3 irq", irq, 1);
    @(negedge clk); chk("R3 irq one cycle", irq, 0);
    chk("R8 flag set", flag, 1);
    wr(2'd2, 16'h0000); chk("R8 write 0 no clear", flag, 1);
    wr(2'd2, 16'h0001); chk("R8 w1c", flag, 0);
  endtask

  task automatic t_underflow();
    set_dir(1'b1);
    wr(2'd0, 16'h0001);
    toggle(); chk("R4 to 0000", count, 16'h0000); chk("R4 no irq", irq, 0);
    toggle(); chk("R4 wrap", count, 16'hFFFF); chk("R4 irq", irq, 1);
    @(negedge clk); chk("R4 irq one cycle", irq, 0);
    chk("R8 flag set dn", flag, 1);
    wr(2'd2, 16'h0001); chk("R8 cleared", flag, 0);
  endtask

  task automatic t_disable();
    set_dir(1'b0);
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h0000); chk("R6 disabled", en, 0);
    for (int i = 0; i < 3; i++) begin
      toggle(); chk("R6 ignored", count, 16'h0010); chk("R6 no irq", irq, 0);
    end
    wr(2'd1, 16'h0001);
    repeat (5) @(negedge clk);
    chk("R6 not queued", count, 16'h0010);
    toggle(); chk("R6 resumes", count, 16'h0011);
  endtask

  task automatic t_write_priority();
    evt = ~evt;
    repeat (2) @(negedge clk);   // strobe live now
    wr(2'd0, 16'h1234);
    chk("R5 write wins", count, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R5 strobe lost", count, 16'h1234);
  endtask

  task automatic t_set_over_clear();
    wr(2'd0, 16'hFFFF);
    evt = ~evt;
    repeat (2) @(negedge clk);
    wr(2'd2, 16'h0001);          // clear lands with the wrap
    chk("R8 wrap value", count, 16'h0000);
    chk("R8 set wins", flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_both_edges();
    t_static();
    t_overflow();
    t_underflow();
    t_disable();
    t_write_priority();
    t_set_over_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule